// File: doc/BRIEF.md
# Descriptor-Driven Configuration Item DMA Engine

This block moves bytes between a small store of configuration items and system memory. Each move is described by a 16-byte descriptor that the host places in memory. The host starts a move by writing the descriptor's 64-bit address into a trigger register. The engine then reads the descriptor, optionally selects a different item, and runs a read, write or skip operation one byte at a time. At the end it overwrites the descriptor's control word with a completion status. Reads of the trigger register return an 8-byte ASCII signature, so that software can detect the engine.

The item store keeps a current selection (item key plus byte offset). A host selector port shares that selection with the engine. The offset carries over from one descriptor to the next, so a long item can be consumed by several descriptors in a row. System memory sits behind a byte-wide request/response port. A request is offered with `mem_req_valid` and is accepted on a cycle where `mem_req_ready` is high. Until it is accepted, the engine holds the address, direction and write data stable. Exactly one response (`mem_rsp_valid` for one cycle) must follow each accepted request, reads and writes alike, before the engine issues its next request. The engine always accepts the response.

Top module: `cfgdma_engine`

## Requirements
- R1: For reads of the trigger register, `reg_rdata` is set combinationally. When the access size is 1, 2, 4 or 8 and offset plus size is at most 8, the value is bytes [offset, offset+size) of the 64-bit signature 0x434647444D417631 ("CFGDMAv1"), with byte 0 as the most significant byte of the constant. This slice appears right-aligned, with the lowest offset in the most significant position. Every other offset and size combination reads 0.
- R2: Only three register writes have any effect, and only while the engine is idle:
  - size 4 at offset 0 loads the high 32 address bits from `reg_wdata[31:0]` and zeroes the low 32 bits;
  - size 4 at offset 4 ORs `reg_wdata[31:0]` into the low bits and starts a transfer;
  - size 8 at offset 0 loads the whole address and starts a transfer.
  All other writes leave the engine idle.
- R3: The stored descriptor address is cleared as soon as a transfer starts, so a later low-half write alone starts at exactly that low value.
- R4: The descriptor is fetched one byte at a time from base+0 to base+15. Bytes 0-3 form the control word, bytes 4-7 the length and bytes 8-15 the memory address, each field big-endian.
- R5: When control bit 3 (select) is set, control bits 31:16 become the new item key before any data moves, and the offset restarts at 0. The same happens on a host `sel_wr` pulse. Keys at or above the item count (4) make the selection invalid. After reset, key 0 is selected at offset 0. With the default parameters, item k holds 8-2k bytes, byte i of item k is 16k+i after reset, and items 1 and 3 are writable.
- R6: The operation is chosen from the control word with priority read (bit 1), then write (bit 4), then skip (bit 2). If none of these bits is set, no data moves and the status is 0.
- R7: A read copies item bytes from the current offset to consecutive memory addresses. Once the selection is invalid or the offset reaches the item end, the read writes zeros for the rest of the length, without error.
- R8: A write copies memory bytes into the item at the current offset, but only for a writable item. A write to a non-writable item, to an invalid selection, or past the item end sets error and changes no item byte.
- R9: A skip advances the offset without any memory traffic. A skip on an invalid selection or past the item end sets error.
- R10: Each byte moved or skipped advances the item offset and the memory address by one and lowers the remaining length by one. The offset carries over to the next descriptor unless that descriptor selects again.
- R11: When the transfer ends, bytes base+0 to base+3 are written with 00 00 00 and then the status byte, which is 01 if an error occurred and 00 otherwise. An error bit already set in the fetched control word is not echoed.
- R12: An error response during the descriptor fetch ends the fetch and writes an error status with no transfer. An error response during the transfer sets error and ends the byte loop.
- R13: `busy` rises the cycle after a transfer starts and falls after the response to the last status byte. While `busy` is high, trigger writes and host `sel_wr` pulses are ignored.
- R14: An offered memory request stays valid with a stable address, direction and data until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Trigger register write strobe |
| reg_addr | input | 3 | Trigger register byte offset |
| reg_size | input | 4 | Access size in bytes |
| reg_wdata | input | 64 | Write data, right-aligned |
| reg_rdata | output | 64 | Signature slice for `reg_addr`/`reg_size` |
| sel_wr | input | 1 | Host selector write strobe |
| sel_key | input | 16 | Host selector key |
| busy | output | 1 | Transfer in progress |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 64 | Byte address |
| mem_req_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | Response strobe |
| mem_rsp_err | input | 1 | Response carries an error |
| mem_rsp_rdata | input | 8 | Read byte |

## Verification
The bench sweeps every key (including an invalid one), every operation mix and lengths up to past the item end. It follows each swept descriptor with a second descriptor that does not select, which shows whether the offset carried over. A design with the wrong priority would move data for the wrong operation. A design that did not zero-fill, or that errored on a short read, would leave stale memory or a 01 status. A design that reset the offset between descriptors would repeat item bytes. Separate cases cover the rest:
- Triggers of the wrong size or at the wrong offset must not start a transfer.
- A stale high address that was not cleared after a start would send the next fetch out of range.
- Memory error responses during the fetch and in the middle of a read must yield an error status and a partial copy.
- Triggers and host selects that arrive while busy must be dropped.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;

  localparam int DESC_BYTES = 16;
  localparam int STAT_BYTES = 4;
  localparam int DESC_W     = DESC_BYTES * 8;

  // control word bit positions (decoded by software, so fixed)
  localparam int CTL_ERR  = 0;
  localparam int CTL_RD   = 1;
  localparam int CTL_SKIP = 2;
  localparam int CTL_SEL  = 3;
  localparam int CTL_WR   = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH_REQ,
    ST_FETCH_RSP,
    ST_PARSE,
    ST_LOOP,
    ST_XFER_REQ,
    ST_XFER_RSP,
    ST_WB_REQ,
    ST_WB_RSP
  } dma_state_t;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_READ,
    OP_WRITE,
    OP_SKIP
  } dma_op_t;

endpackage

// File: rtl/cfgdma_trigger.sv
module cfgdma_trigger #(
  parameter logic [63:0] SIG = 64'h4346_4744_4D41_7631
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [3:0]  reg_size,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  input  logic        busy,
  output logic        start,
  output logic [63:0] start_addr
);

  logic [63:0] addr_q;
  logic        wr_hi, wr_lo, wr_full;

  assign wr_hi   = reg_wr && !busy && (reg_size == 4'd4) && (reg_addr == 3'd0);
  assign wr_lo   = reg_wr && !busy && (reg_size == 4'd4) && (reg_addr == 3'd4);
  assign wr_full = reg_wr && !busy && (reg_size == 4'd8) && (reg_addr == 3'd0);

  assign start      = wr_lo || wr_full;
  assign start_addr = wr_full ? reg_wdata : (addr_q | {32'd0, reg_wdata[31:0]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (start)   addr_q <= '0;
    else if (wr_hi)   addr_q <= {reg_wdata[31:0], 32'd0};
  end

  // signature slice, lowest offset lands in the most significant byte
  always_comb begin
    int          sz;
    logic [63:0] shifted;
    reg_rdata = '0;
    shifted   = '0;
    case (reg_size)
      4'd1, 4'd2, 4'd4, 4'd8: sz = int'(reg_size);
      default:                sz = 0;
    endcase
    if (sz != 0 && (int'(reg_addr) + sz) <= 8) begin
      shifted = SIG >> (8 * (8 - int'(reg_addr) - sz));
      if (sz == 8) reg_rdata = shifted;
      else         reg_rdata = shifted & ((64'd1 << (8 * sz)) - 64'd1);
    end
  end

  p_clear_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (addr_q == 64'd0));

endmodule

// File: rtl/cfgdma_item_store.sv
module cfgdma_item_store #(
  parameter int                  ITEM_CNT = 4,
  parameter int                  ITEM_MAX = 8,
  parameter logic [ITEM_CNT-1:0] WR_MASK  = 4'b1010,
  localparam int IDX_W    = (ITEM_CNT > 1) ? $clog2(ITEM_CNT) : 1,
  localparam int IX_W     = (ITEM_MAX > 1) ? $clog2(ITEM_MAX) : 1,
  localparam int OFF_W    = $clog2(ITEM_MAX + 1),
  localparam int LEN_STEP = ITEM_MAX / ITEM_CNT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_en,
  input  logic [15:0]      sel_key,
  input  logic             adv,
  input  logic             wen,
  input  logic [7:0]       wbyte,
  output logic             ent_valid,
  output logic [OFF_W-1:0] ent_len,
  output logic [OFF_W-1:0] ent_off,
  output logic             ent_wr_ok,
  output logic [7:0]       ent_rbyte
);

  logic [IDX_W-1:0] key_q;
  logic             valid_q;
  logic [OFF_W-1:0] off_q;
  logic [7:0]       bytes_q [ITEM_CNT][ITEM_MAX];

  function automatic logic [OFF_W-1:0] item_len(input int k);
    return OFF_W'(ITEM_MAX - k * LEN_STEP);
  endfunction

  assign ent_valid = valid_q;
  assign ent_off   = off_q;
  assign ent_len   = item_len(int'(key_q));
  assign ent_wr_ok = valid_q && WR_MASK[key_q];
  assign ent_rbyte = bytes_q[key_q][off_q[IX_W-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q   <= '0;
      valid_q <= 1'b1;
      off_q   <= '0;
    end else if (sel_en) begin
      key_q   <= sel_key[IDX_W-1:0];
      valid_q <= (sel_key < 16'(ITEM_CNT));
      off_q   <= '0;
    end else if (adv) begin
      off_q   <= off_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < ITEM_CNT; k++)
        for (int i = 0; i < ITEM_MAX; i++)
          bytes_q[k][i] <= 8'(k * 16 + i);
    end else if (wen && ent_wr_ok && (off_q < ent_len)) begin
      bytes_q[key_q][off_q[IX_W-1:0]] <= wbyte;
    end
  end

  p_adv_in_item_r10: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (valid_q && off_q < ent_len));

  p_off_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (off_q <= ent_len));

  p_write_needs_perm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wen |-> ent_wr_ok);

endmodule

// File: rtl/cfgdma_core.sv
module cfgdma_core
  import cfgdma_pkg::*;
#(
  parameter int OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [63:0]      start_addr,
  output logic             busy,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_we,
  output logic [63:0]      mem_req_addr,
  output logic [7:0]       mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic             mem_rsp_err,
  input  logic [7:0]       mem_rsp_rdata,
  output logic             sel_en,
  output logic [15:0]      sel_key,
  output logic             adv,
  output logic             wen,
  output logic [7:0]       wbyte,
  input  logic             ent_valid,
  input  logic [OFF_W-1:0] ent_len,
  input  logic [OFF_W-1:0] ent_off,
  input  logic             ent_wr_ok,
  input  logic [7:0]       ent_rbyte
);

  dma_state_t        state_q;
  dma_op_t           op_q, nxt_op;
  logic [63:0]       base_q, addr_q;
  logic [3:0]        cnt_q;
  logic [DESC_W-1:0] desc_q;
  logic [31:0]       len_q;
  logic              err_q, x_we_q, x_item_q;
  logic [7:0]        x_data_q;
  logic [31:0]       ctl_w, dlen_w;
  logic [63:0]       daddr_w;
  logic              in_item, rsp_ok;
  logic              unused_ctl_bits;

  assign ctl_w   = desc_q[127:96];
  assign dlen_w  = desc_q[95:64];
  assign daddr_w = desc_q[63:0];
  assign unused_ctl_bits = ^{ctl_w[15:5], ctl_w[CTL_ERR]};

  always_comb begin
    if (ctl_w[CTL_RD])        nxt_op = OP_READ;
    else if (ctl_w[CTL_WR])   nxt_op = OP_WRITE;
    else if (ctl_w[CTL_SKIP]) nxt_op = OP_SKIP;
    else                      nxt_op = OP_NONE;
  end

  assign in_item = ent_valid && (ent_off < ent_len);
  assign rsp_ok  = (state_q == ST_XFER_RSP) && mem_rsp_valid && !mem_rsp_err;
  assign busy    = (state_q != ST_IDLE);

  assign sel_en  = (state_q == ST_PARSE) && ctl_w[CTL_SEL];
  assign sel_key = ctl_w[31:16];
  assign adv     = (rsp_ok && x_item_q) ||
                   ((state_q == ST_LOOP) && !err_q && (len_q != 0) &&
                    in_item && (op_q == OP_SKIP));
  assign wen     = rsp_ok && x_item_q && (op_q == OP_WRITE);
  assign wbyte   = mem_rsp_rdata;

  assign mem_req_valid = (state_q == ST_FETCH_REQ) || (state_q == ST_XFER_REQ) ||
                         (state_q == ST_WB_REQ);
  assign mem_req_addr  = (state_q == ST_XFER_REQ) ? addr_q : (base_q + 64'(cnt_q));
  assign mem_req_we    = (state_q == ST_XFER_REQ) ? x_we_q : (state_q == ST_WB_REQ);
  assign mem_req_wdata = (state_q == ST_XFER_REQ) ? x_data_q :
                         ((state_q == ST_WB_REQ) && cnt_q == 4'(STAT_BYTES - 1)) ?
                         {7'd0, err_q} : 8'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_NONE;
      base_q   <= '0;
      addr_q   <= '0;
      cnt_q    <= '0;
      desc_q   <= '0;
      len_q    <= '0;
      err_q    <= 1'b0;
      x_we_q   <= 1'b0;
      x_item_q <= 1'b0;
      x_data_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          base_q  <= start_addr;
          cnt_q   <= '0;
          err_q   <= 1'b0;
          state_q <= ST_FETCH_REQ;
        end
        ST_FETCH_REQ: if (mem_req_ready) state_q <= ST_FETCH_RSP;
        ST_FETCH_RSP: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            err_q   <= 1'b1;
            cnt_q   <= '0;
            state_q <= ST_WB_REQ;
          end else begin
            desc_q <= {desc_q[DESC_W-9:0], mem_rsp_rdata};
            if (cnt_q == 4'(DESC_BYTES - 1)) begin
              cnt_q   <= '0;
              state_q <= ST_PARSE;
            end else begin
              cnt_q   <= cnt_q + 1'b1;
              state_q <= ST_FETCH_REQ;
            end
          end
        end
        ST_PARSE: begin
          op_q    <= nxt_op;
          len_q   <= (nxt_op == OP_NONE) ? 32'd0 : dlen_w;
          addr_q  <= daddr_w;
          err_q   <= 1'b0;
          state_q <= ST_LOOP;
        end
        ST_LOOP: begin
          if (len_q == 0 || err_q) begin
            cnt_q   <= '0;
            state_q <= ST_WB_REQ;
          end else if (!in_item) begin
            if (op_q == OP_READ) begin
              x_we_q   <= 1'b1;
              x_data_q <= 8'd0;
              x_item_q <= 1'b0;
              state_q  <= ST_XFER_REQ;
            end else begin
              err_q <= 1'b1;
            end
          end else begin
            case (op_q)
              OP_READ: begin
                x_we_q   <= 1'b1;
                x_data_q <= ent_rbyte;
                x_item_q <= 1'b1;
                state_q  <= ST_XFER_REQ;
              end
              OP_WRITE: begin
                if (!ent_wr_ok) err_q <= 1'b1;
                else begin
                  x_we_q   <= 1'b0;
                  x_data_q <= 8'd0;
                  x_item_q <= 1'b1;
                  state_q  <= ST_XFER_REQ;
                end
              end
              default: begin
                len_q  <= len_q - 1'b1;
                addr_q <= addr_q + 1'b1;
              end
            endcase
          end
        end
        ST_XFER_REQ: if (mem_req_ready) state_q <= ST_XFER_RSP;
        ST_XFER_RSP: if (mem_rsp_valid) begin
          if (mem_rsp_err) err_q <= 1'b1;
          else begin
            len_q  <= len_q - 1'b1;
            addr_q <= addr_q + 1'b1;
          end
          state_q <= ST_LOOP;
        end
        ST_WB_REQ: if (mem_req_ready) state_q <= ST_WB_RSP;
        ST_WB_RSP: if (mem_rsp_valid) begin
          if (cnt_q == 4'(STAT_BYTES - 1)) state_q <= ST_IDLE;
          else begin
            cnt_q   <= cnt_q + 1'b1;
            state_q <= ST_WB_REQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_req_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) &&
       $stable(mem_req_wdata)));

  p_idle_after_rsp_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_rsp_valid));

  p_select_in_transfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_en |-> busy);

endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine #(
  parameter int                  ITEM_CNT = 4,
  parameter int                  ITEM_MAX = 8,
  parameter logic [ITEM_CNT-1:0] WR_MASK  = 4'b1010,
  parameter logic [63:0]         SIG      = 64'h4346_4744_4D41_7631,
  localparam int OFF_W = $clog2(ITEM_MAX + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [3:0]  reg_size,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  input  logic        sel_wr,
  input  logic [15:0] sel_key,
  output logic        busy,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_we,
  output logic [63:0] mem_req_addr,
  output logic [7:0]  mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic        mem_rsp_err,
  input  logic [7:0]  mem_rsp_rdata
);

  logic             start;
  logic [63:0]      start_addr;
  logic             core_sel, st_sel, adv, wen;
  logic [15:0]      core_key, st_key;
  logic [7:0]       wbyte, ent_rbyte;
  logic             ent_valid, ent_wr_ok;
  logic [OFF_W-1:0] ent_len, ent_off;

  cfgdma_trigger #(.SIG(SIG)) u_trig (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_size, .reg_wdata, .reg_rdata,
    .busy, .start, .start_addr
  );

  // host selections are dropped while a transfer owns the store
  assign st_sel = core_sel || (sel_wr && !busy);
  assign st_key = core_sel ? core_key : sel_key;

  cfgdma_item_store #(.ITEM_CNT(ITEM_CNT), .ITEM_MAX(ITEM_MAX), .WR_MASK(WR_MASK)) u_store (
    .clk, .rst_n, .sel_en(st_sel), .sel_key(st_key), .adv, .wen, .wbyte,
    .ent_valid, .ent_len, .ent_off, .ent_wr_ok, .ent_rbyte
  );

  cfgdma_core #(.OFF_W(OFF_W)) u_core (
    .clk, .rst_n, .start, .start_addr, .busy,
    .mem_req_valid, .mem_req_ready, .mem_req_we, .mem_req_addr, .mem_req_wdata,
    .mem_rsp_valid, .mem_rsp_err, .mem_rsp_rdata,
    .sel_en(core_sel), .sel_key(core_key), .adv, .wen, .wbyte,
    .ent_valid, .ent_len, .ent_off, .ent_wr_ok, .ent_rbyte
  );

  p_start_when_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

endmodule

// File: tb/cfgdma_engine_tb.sv
module cfgdma_engine_tb;

  localparam logic [63:0] SIG = 64'h4346_4744_4D41_7631;
  localparam logic [63:0] DB  = 64'hC0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [3:0]  reg_size = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        sel_wr = 1'b0;
  logic [15:0] sel_key = '0;
  logic        busy;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic [7:0]  mem_req_wdata;
  logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [7:0]  mem_rsp_rdata = '0;

  int n_chk = 0, n_bad = 0;
  logic [7:0]  mem [256];
  logic [7:0]  exp_mem [256];
  logic [7:0]  itm [4][8];
  int          m_key, m_off;
  bit          m_valid;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  cfgdma_engine u_dut (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_size, .reg_wdata, .reg_rdata,
    .sel_wr, .sel_key, .busy, .mem_req_valid, .mem_req_ready, .mem_req_we,
    .mem_req_addr, .mem_req_wdata, .mem_rsp_valid, .mem_rsp_err, .mem_rsp_rdata
  );

  // memory model: pseudo-random back-pressure, one-cycle response
  always @(posedge clk) begin
    lfsr          <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_req_ready <= lfsr[0] | lfsr[5];
    mem_rsp_valid <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      if (mem_req_addr[63:8] != 0) mem_rsp_err <= 1'b1;
      else begin
        mem_rsp_err <= 1'b0;
        if (mem_req_we) mem[mem_req_addr[7:0]] <= mem_req_wdata;
        else            mem_rsp_rdata <= mem[mem_req_addr[7:0]];
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  function automatic int ilen(input int k);
    return 8 - 2 * k;
  endfunction

  function automatic bit iwr(input int k);
    return (k == 1) || (k == 3);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_mem(input string tag);
    int bad = 0, first = -1;
    for (int i = 0; i < 256; i++)
      if (mem[i] !== exp_mem[i]) begin bad++; if (first < 0) first = i; end
    n_chk++;
    if (bad != 0) begin
      n_bad++;
      $display("FAIL %s: %0d bytes differ, addr %0d actual %h expected %h",
               tag, bad, first, mem[first], exp_mem[first]);
    end
  endtask

  task automatic put_desc(input logic [7:0] b, input logic [31:0] ctl,
                          input logic [31:0] len, input logic [63:0] addr);
    logic [127:0] d;
    d = {ctl, len, addr};
    for (int i = 0; i < 16; i++) begin
      mem[b + 8'(i)]     = d[127 - 8*i -: 8];
      exp_mem[b + 8'(i)] = d[127 - 8*i -: 8];
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [3:0] s, input logic [63:0] w);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_size = s; reg_wdata = w;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic host_select(input logic [15:0] k);
    @(negedge clk);
    sel_wr = 1'b1; sel_key = k;
    @(negedge clk);
    sel_wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // reference behaviour from the requirements, applied to exp_mem and itm
  task automatic model(input logic [63:0] base);
    logic [31:0] ctl, len;
    logic [63:0] a;
    int op; bit err;
    err = 1'b0;
    if (base[63:8] != 0 || base[7:0] > 8'd240) err = 1'b1;
    else begin
      ctl = '0; len = '0; a = '0;
      for (int i = 0; i < 4; i++) ctl = {ctl[23:0], exp_mem[base[7:0] + 8'(i)]};
      for (int i = 4; i < 8; i++) len = {len[23:0], exp_mem[base[7:0] + 8'(i)]};
      for (int i = 8; i < 16; i++) a = {a[55:0], exp_mem[base[7:0] + 8'(i)]};
      if (ctl[3]) begin m_key = int'(ctl[31:16]); m_valid = (m_key < 4); m_off = 0; end
      op = ctl[1] ? 1 : ctl[4] ? 2 : ctl[2] ? 3 : 0;
      if (op == 0) len = 0;
      while (len != 0 && !err) begin
        if (!m_valid || m_off >= ilen(m_key)) begin
          if (op == 1 && a < 256) begin exp_mem[a[7:0]] = 8'd0; a++; len--; end
          else err = 1'b1;
        end else if (op == 1) begin
          if (a >= 256) err = 1'b1;
          else begin exp_mem[a[7:0]] = itm[m_key][m_off]; a++; len--; m_off++; end
        end else if (op == 2) begin
          if (!iwr(m_key) || a >= 256) err = 1'b1;
          else begin itm[m_key][m_off] = exp_mem[a[7:0]]; a++; len--; m_off++; end
        end else begin
          a++; len--; m_off++;
        end
      end
    end
    for (int i = 0; i < 4; i++)
      if (base + 64'(i) < 256) exp_mem[base[7:0] + 8'(i)] = (i == 3) ? {7'd0, err} : 8'd0;
  endtask

  task automatic run8(input logic [63:0] base, input string tag);
    reg_write(3'd0, 4'd8, base);
    check({tag, " R13 busy after start"}, 64'(busy), 64'd1);
    wait_idle();
    model(base);
    compare_mem(tag);
  endtask

  initial begin
    int ctl_ops [5] = '{32'h00, 32'h02, 32'h10, 32'h04, 32'h16};
    string ctl_tag [5] = '{"R6 none", "R7 read", "R8 write", "R9 skip", "R6 priority"};
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i) ^ 8'h5A; exp_mem[i] = mem[i]; end
    for (int k = 0; k < 4; k++) for (int i = 0; i < 8; i++) itm[k][i] = 8'(16*k + i);
    m_key = 0; m_off = 0; m_valid = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R13 reset idle", 64'(busy), 64'd0);
    check("R14 reset no request", 64'(mem_req_valid), 64'd0);

    // R1 signature sweep over every offset and size
    for (int a = 0; a < 8; a++)
      for (int s = 0; s < 9; s++) begin
        logic [63:0] e;
        e = 64'd0;
        if ((s == 1 || s == 2 || s == 4 || s == 8) && a + s <= 8) begin
          for (int j = 0; j < s; j++) e = {e[55:0], SIG[63 - 8*(a+j) -: 8]};
        end
        @(negedge clk);
        reg_addr = 3'(a); reg_size = 4'(s);
        #1 check($sformatf("R1 signature off %0d size %0d", a, s), reg_rdata, e);
      end

    // R5 reset selection: read key 0 without select
    put_desc(8'hC0, 32'h0000_0002, 32'd3, 64'h40);
    run8(DB, "R5 reset selection read");

    // R2 malformed trigger writes do nothing
    put_desc(8'hA0, 32'h0001_000A, 32'd4, 64'h60);
    reg_write(3'd0, 4'd2, 64'hA0);
    check("R2 size2 ignored", 64'(busy), 64'd0);
    reg_write(3'd2, 4'd4, 64'hA0);
    check("R2 off2 ignored", 64'(busy), 64'd0);
    reg_write(3'd4, 4'd8, 64'hA0);
    check("R2 size8 off4 ignored", 64'(busy), 64'd0);
    reg_write(3'd4, 4'd1, 64'hA0);
    check("R2 size1 ignored", 64'(busy), 64'd0);
    compare_mem("R2 memory untouched");

    // R2/R3 split write with high half, then a lone low-half write
    reg_write(3'd0, 4'd4, 64'h1);
    reg_write(3'd4, 4'd4, 64'hC0);
    wait_idle();
    model(64'h1_0000_00C0);
    compare_mem("R12 out-of-range fetch");
    reg_write(3'd4, 4'd4, 64'hA0);
    check("R3 lone low write starts", 64'(busy), 64'd1);
    wait_idle();
    model(64'hA0);
    compare_mem("R3 address cleared after start");

    // main sweep: key x operation x length, then a no-select follow-up
    for (int k = 0; k < 5; k++)
      for (int o = 0; o < 5; o++)
        for (int l = 0; l < 10; l++) begin
          for (int i = 0; i < 16; i++) begin
            mem[8'h10 + 8'(i)] = 8'(k*37 + l*11 + i);
            exp_mem[8'h10 + 8'(i)] = mem[8'h10 + 8'(i)];
          end
          put_desc(8'hC0, {16'(k), 16'(ctl_ops[o]) | 16'h8 | 16'(l & 1)}, 32'(l), 64'h10);
          run8(DB, $sformatf("%s key %0d len %0d (R4 R11)", ctl_tag[o], k, l));
          put_desc(8'hC0, 32'h0000_0002, 32'd3, 64'h30);
          run8(DB, $sformatf("R10 carry-over key %0d len %0d", k, l));
        end

    // R12 memory error in the middle of a read
    put_desc(8'hC0, 32'h0000_000A, 32'd8, 64'hFC);
    run8(DB, "R12 mid-read error");
    put_desc(8'hC0, 32'h0000_0002, 32'd4, 64'h20);
    run8(DB, "R12 offset after partial read");
    // R12 fetch that runs off the end of memory
    put_desc(8'hF8, 32'h0000_0002, 32'd1, 64'h20);
    run8(64'hF8, "R12 fetch error status");

    // R5 host selector, valid and invalid keys
    host_select(16'd2);
    m_key = 2; m_valid = 1'b1; m_off = 0;
    put_desc(8'hC0, 32'h0000_0002, 32'd5, 64'h40);
    run8(DB, "R5 host select read");
    host_select(16'd9);
    m_key = 9; m_valid = 1'b0; m_off = 0;
    put_desc(8'hC0, 32'h0000_0004, 32'd1, 64'h40);
    run8(DB, "R9 skip on invalid host key");

    // R13 triggers and host selects during a transfer are dropped
    put_desc(8'hC0, 32'h0001_000A, 32'd9, 64'h50);
    put_desc(8'hA0, 32'h0000_0002, 32'd4, 64'h70);
    reg_write(3'd0, 4'd8, DB);
    reg_write(3'd0, 4'd8, 64'hA0);
    host_select(16'd3);
    wait_idle();
    model(DB);
    compare_mem("R13 trigger while busy dropped");
    put_desc(8'hC0, 32'h0000_0002, 32'd2, 64'h58);
    run8(DB, "R13 host select while busy dropped");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule